// File: doc/BRIEF.md
# Modulus Event Counter

This block is a 16-bit up-counter that steps once per count pulse and, when it passes its top value, reloads from a programmable modulus register in place of wrapping to zero. Software picks the count pulse source through a clock-select field. The choices are one of six prescaler enable taps, or a rising or a falling edge on an external clock pin. Both external pins pass through a synchronizer before use. External events are counted reliably up to one quarter of the system clock rate. A second external pin, the load pin, can force a reload from the modulus register on a rising edge, a falling edge, or both. Both load edge enables are off after reset.

Each overflow sets a sticky flag. An interrupt request is raised while that flag is set and a 3-bit priority level is nonzero. A modulus of zero turns the block into a plain free-running counter. Presetting the counter to the two's complement of N makes the overflow, and so the interrupt, happen on the Nth counted event. Software reads and writes three registers through a simple synchronous port. It also reads the synchronized levels of both pins.

Top module: `mod_event_counter`

## Requirements
- R1: With clock-select 0 to 5, the counter adds one on each cycle in which `presc_en[sel]` is high, and the other taps have no effect. Register map: address 0 is control/status, address 1 is the counter, address 2 is the modulus. The read data is registered and shows the addressed register one clock after the address is applied. Control bits [2:0] hold the clock-select field.
- R2: Clock-select 6 counts rising edges and clock-select 7 counts falling edges of `ext_clk_pin`. Each edge counts exactly once, three clocks after the pin changes, and the prescaler taps are ignored in these modes.
- R3: A count pulse taken while the counter holds 0xFFFF loads the modulus value and sets the overflow flag (control bit 8) in the same clock.
- R4: With a modulus of 0x0000, the counter runs freely and goes from 0xFFFF to 0x0000, setting the overflow flag.
- R5: `irq` is high exactly when the overflow flag is set and the level field (control bits [7:5], also driven on `irq_level`) is nonzero.
- R6: The overflow flag stays set until a control write with bit 8 equal to 0. A control write with bit 8 equal to 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write wins.
- R7: After the counter is preset to the two's complement of N, the overflow flag is still clear after N-1 counted events and is set by the Nth.
- R8: Control bit 3 enables reload on a rising edge of `ext_load_pin` and bit 4 enables reload on a falling edge. Both are 0 after reset, and an edge whose enable is 0 leaves the counter unchanged.
- R9: When a load-pin reload and a count pulse fall in the same clock, the counter takes the modulus value and does not count.
- R10: Control bit 9 reads the synchronized level of `ext_load_pin`, and bit 10 reads the synchronized level of `ext_clk_pin`.
- R11: A count pulse in the first clock after a control write that changes the clock-select field is discarded, so a source change cannot make a spurious count.
- R12: After reset, all three registers read zero and `irq` is low. A write to address 1 loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_en | input | 6 | Prescaler tap enables, one per tap |
| ext_clk_pin | input | 1 | Asynchronous external event/clock pin |
| ext_load_pin | input | 1 | Asynchronous external reload pin |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt priority level |

## Verification
The hardest situation to reach is two events landing in the same clock. The first case is a load-pin reload and a count pulse together. The pin needs two synchronizer stages and an edge register before its pulse exists, so the bench raises the pin and then strobes a prescaler tap exactly two falling clock edges later. That lines both pulses up on one rising edge. The second case is a count pulse in the single clock after a select change. The bench drives the selected tap on the falling edge that ends the control write, so the first pulse lands in the masked cycle and a second, later pulse proves counting resumes.

// File: rtl/mec_pkg.sv
package mec_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_MOD   = 2'd2
  } reg_addr_e;

  localparam int B_SEL_LO = 0;
  localparam int B_LD_RISE = 3;
  localparam int B_LD_FALL = 4;
  localparam int B_LVL_LO = 5;
  localparam int LVL_W = 3;
  localparam int B_OVF = 8;
  localparam int B_LD_PIN = 9;
  localparam int B_CK_PIN = 10;
endpackage

// File: rtl/mec_edge_sync.sv
module mec_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

  // R2: every qualifying edge yields a single-cycle pulse
  p_one_rise_r2: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
  p_one_fall_r2: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/mec_src_sel.sv
module mec_src_sel #(
  parameter int NUM_TAPS = 6,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] presc_en,
  input  logic                ext_rise,
  input  logic                ext_fall,
  input  logic [SEL_W-1:0]    sel,
  input  logic                sel_change,
  output logic                count_en
);
  localparam int NUM_SRC = NUM_TAPS + 2;

  logic [NUM_SRC-1:0] src;
  logic               raw;
  logic               mask_q;

  assign src = {ext_fall, ext_rise, presc_en};

  always_comb begin
    raw = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) raw = src[i];
    end
  end

  // one dead cycle after the select changes
  always_ff @(posedge clk) begin
    if (rst) mask_q <= 1'b0;
    else     mask_q <= sel_change;
  end

  assign count_en = raw & ~mask_q;
endmodule

// File: rtl/mec_count_core.sv
module mec_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          count_en,
  input  logic          load_pulse,
  input  logic          cnt_wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] modulus,
  output logic [CW-1:0] cnt_q,
  output logic          wrap
);
  localparam logic [CW-1:0] TOP = '1;

  logic at_top;
  assign at_top = (cnt_q == TOP);
  assign wrap   = count_en & at_top & ~cnt_wr & ~load_pulse;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (cnt_wr)      cnt_q <= wdata;
    else if (load_pulse)  cnt_q <= modulus;
    else if (count_en)    cnt_q <= at_top ? modulus : cnt_q + 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (count_en && !load_pulse && !cnt_wr && !at_top) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (count_en && !load_pulse && !cnt_wr && at_top) |=> cnt_q == $past(modulus));
  p_load_prio_r9: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && !cnt_wr) |=> cnt_q == $past(modulus));
endmodule

// File: rtl/mod_event_counter.sv
module mod_event_counter
  import mec_pkg::*;
#(
  parameter int CW          = 16,
  parameter int NUM_TAPS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TAPS-1:0] presc_en,
  input  logic                ext_clk_pin,
  input  logic                ext_load_pin,
  input  logic                wr_en,
  input  logic [1:0]          addr,
  input  logic [CW-1:0]       wdata,
  output logic [CW-1:0]       rdata,
  output logic                irq,
  output logic [LVL_W-1:0]    irq_level
);
  localparam int SEL_W = $clog2(NUM_TAPS + 2);

  logic [SEL_W-1:0] sel_q;
  logic             ld_rise_en_q, ld_fall_en_q;
  logic [LVL_W-1:0] lvl_q;
  logic             ovf_q;
  logic [CW-1:0]    mod_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    ctrl_view;

  logic ck_level, ck_rise, ck_fall;
  logic ld_level, ld_rise, ld_fall;
  logic ctrl_wr, cnt_wr, mod_wr, sel_change;
  logic load_pulse, count_en, wrap;
  logic [SEL_W-1:0] new_sel;

  assign ctrl_wr    = wr_en && (addr == REG_CTRL);
  assign cnt_wr     = wr_en && (addr == REG_COUNT);
  assign mod_wr     = wr_en && (addr == REG_MOD);
  assign new_sel    = wdata[B_SEL_LO +: SEL_W];
  assign sel_change = ctrl_wr && (new_sel != sel_q);

  mec_edge_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
    .clk(clk), .rst(rst), .pin(ext_clk_pin),
    .level(ck_level), .rise(ck_rise), .fall(ck_fall));

  mec_edge_sync #(.STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(clk), .rst(rst), .pin(ext_load_pin),
    .level(ld_level), .rise(ld_rise), .fall(ld_fall));

  mec_src_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_src (
    .clk(clk), .rst(rst), .presc_en(presc_en),
    .ext_rise(ck_rise), .ext_fall(ck_fall),
    .sel(sel_q), .sel_change(sel_change), .count_en(count_en));

  assign load_pulse = (ld_rise_en_q & ld_rise) | (ld_fall_en_q & ld_fall);

  mec_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .count_en(count_en), .load_pulse(load_pulse),
    .cnt_wr(cnt_wr), .wdata(wdata), .modulus(mod_q),
    .cnt_q(cnt_q), .wrap(wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q        <= '0;
      ld_rise_en_q <= 1'b0;
      ld_fall_en_q <= 1'b0;
      lvl_q        <= '0;
      mod_q        <= '0;
    end else begin
      if (ctrl_wr) begin
        sel_q        <= new_sel;
        ld_rise_en_q <= wdata[B_LD_RISE];
        ld_fall_en_q <= wdata[B_LD_FALL];
        lvl_q        <= wdata[B_LVL_LO +: LVL_W];
      end
      if (mod_wr) mod_q <= wdata;
    end
  end

  // sticky flag: set wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst)                             ovf_q <= 1'b0;
    else if (wrap)                       ovf_q <= 1'b1;
    else if (ctrl_wr && !wdata[B_OVF])   ovf_q <= 1'b0;
  end

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[B_SEL_LO +: SEL_W]     = sel_q;
    ctrl_view[B_LD_RISE]             = ld_rise_en_q;
    ctrl_view[B_LD_FALL]             = ld_fall_en_q;
    ctrl_view[B_LVL_LO +: LVL_W]     = lvl_q;
    ctrl_view[B_OVF]                 = ovf_q;
    ctrl_view[B_LD_PIN]              = ld_level;
    ctrl_view[B_CK_PIN]              = ck_level;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        REG_CTRL:  rdata <= ctrl_view;
        REG_COUNT: rdata <= cnt_q;
        REG_MOD:   rdata <= mod_q;
        default:   rdata <= '0;
      endcase
    end
  end

  assign irq       = ovf_q & (lvl_q != '0);
  assign irq_level = lvl_q;

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ctrl_wr) |=> ovf_q);
  p_wrap_sets_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_q);
  p_sel_mask_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_change) && !load_pulse && !cnt_wr) |=> cnt_q == $past(cnt_q));
  p_no_irq_lvl0_r5: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0) |-> !irq);
endmodule

// File: tb/mod_event_counter_bench.sv
module mod_event_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  presc_en = '0;
  logic        ext_clk_pin = 1'b0;
  logic        ext_load_pin = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mod_event_counter u_mod_event_counter (
    .clk(clk), .rst(rst), .presc_en(presc_en), .ext_clk_pin(ext_clk_pin),
    .ext_load_pin(ext_load_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .irq_level(irq_level));

  function automatic logic [15:0] ctl(int sel, int ldr, int ldf, int lvl);
    return 16'((sel & 7) | ((ldr & 1) << 3) | ((ldf & 1) << 4) | ((lvl & 7) << 5));
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 d = rdata;
  endtask

  task automatic tap(int i);
    @(negedge clk);
    presc_en = 6'(1 << i);
    @(negedge clk);
    presc_en = '0;
  endtask

  task automatic ck_pulse();
    @(negedge clk); ext_clk_pin = 1'b1;
    repeat (4) @(negedge clk);
    ext_clk_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ld_set(logic v);
    @(negedge clk); ext_load_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R12 ctrl after reset", d, 16'h0000);
    rd(2'd1, d); check("R12 count after reset", d, 16'h0000);
    rd(2'd2, d); check("R12 modulus after reset", d, 16'h0000);
    check("R12 irq after reset", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_taps();
    logic [15:0] d;
    wr(2'd0, ctl(2, 0, 0, 0));
    wr(2'd1, 16'h0000);
    rd(2'd1, d); check("R12 direct counter write", d, 16'h0000);
    for (int k = 0; k < 5; k++) tap(2);
    for (int k = 0; k < 3; k++) tap(0);
    tap(5);
    rd(2'd1, d); check("R1 tap 2 counted, others ignored", d, 16'd5);
  endtask

  task automatic t_ext_edges();
    logic [15:0] d;
    wr(2'd0, ctl(6, 0, 0, 0));
    wr(2'd1, 16'h0000);
    for (int k = 0; k < 3; k++) ck_pulse();
    @(negedge clk); presc_en = 6'h3f; @(negedge clk); presc_en = '0;
    rd(2'd1, d); check("R2 rising edges counted once each", d, 16'd3);
    wr(2'd0, ctl(7, 0, 0, 0));
    wr(2'd1, 16'h0000);
    for (int k = 0; k < 2; k++) ck_pulse();
    rd(2'd1, d); check("R2 falling edges counted once each", d, 16'd2);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd2, 16'h1234);
    wr(2'd1, 16'hFFFE);
    tap(0);
    rd(2'd0, d); check("R3 no flag before top", 16'(d[8]), 16'd0);
    tap(0);
    rd(2'd1, d); check("R3 reload from modulus", d, 16'h1234);
    rd(2'd0, d); check("R3 overflow flag set", 16'(d[8]), 16'd1);
  endtask

  task automatic t_free_irq();
    logic [15:0] d;
    wr(2'd2, 16'h0000);
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd1, 16'hFFFF);
    tap(0);
    rd(2'd1, d); check("R4 free-running wrap to zero", d, 16'h0000);
    rd(2'd0, d); check("R4 overflow flag on free wrap", 16'(d[8]), 16'd1);
    check("R5 irq low while level is zero", {15'd0, irq}, 16'd0);
    wr(2'd0, ctl(0, 0, 0, 3) | 16'h0100);
    check("R5 irq high with flag and level 3", {15'd0, irq}, 16'd1);
    check("R5 irq_level output", {13'd0, irq_level}, 16'd3);
    rd(2'd0, d); check("R6 writing 1 keeps flag", 16'(d[8]), 16'd1);
    wr(2'd0, ctl(0, 0, 0, 3));
    check("R6 irq drops after clear", {15'd0, irq}, 16'd0);
    rd(2'd0, d); check("R6 writing 0 clears flag", 16'(d[8]), 16'd0);
  endtask

  task automatic t_preset();
    logic [15:0] d;
    wr(2'd2, 16'h0100);
    wr(2'd0, ctl(6, 0, 0, 0));
    wr(2'd1, 16'hFFFC);
    for (int k = 0; k < 3; k++) ck_pulse();
    rd(2'd0, d); check("R7 no overflow after N-1 events", 16'(d[8]), 16'd0);
    ck_pulse();
    rd(2'd0, d); check("R7 overflow on Nth event", 16'(d[8]), 16'd1);
    rd(2'd1, d); check("R7 reload after Nth event", d, 16'h0100);
  endtask

  task automatic t_load_edges();
    logic [15:0] d;
    wr(2'd0, ctl(0, 0, 0, 0));
    wr(2'd2, 16'h0ABC);
    wr(2'd1, 16'h0005);
    ld_set(1'b1); ld_set(1'b0);
    rd(2'd1, d); check("R8 no reload with enables clear", d, 16'h0005);
    wr(2'd0, ctl(0, 1, 0, 0));
    ld_set(1'b1);
    rd(2'd1, d); check("R8 rising edge reloads", d, 16'h0ABC);
    wr(2'd1, 16'h0005);
    ld_set(1'b0);
    rd(2'd1, d); check("R8 falling edge ignored when disabled", d, 16'h0005);
    wr(2'd0, ctl(0, 0, 1, 0));
    ld_set(1'b1);
    rd(2'd1, d); check("R8 rising edge ignored when disabled", d, 16'h0005);
    ld_set(1'b0);
    rd(2'd1, d); check("R8 falling edge reloads", d, 16'h0ABC);
  endtask

  task automatic t_load_prio();
    logic [15:0] d;
    wr(2'd0, ctl(0, 1, 0, 0));
    wr(2'd2, 16'h0400);
    wr(2'd1, 16'h0010);
    @(negedge clk); ext_load_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); presc_en = 6'h01;
    @(negedge clk); presc_en = '0;
    repeat (2) @(negedge clk);
    rd(2'd1, d); check("R9 load wins over same-cycle count", d, 16'h0400);
    ld_set(1'b0);
  endtask

  task automatic t_pins();
    logic [15:0] d;
    wr(2'd0, ctl(0, 0, 0, 0));
    rd(2'd0, d); check("R10 both pins low", 16'(d[10:9]), 16'd0);
    @(negedge clk); ext_load_pin = 1'b1; ext_clk_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R10 load pin high", 16'(d[10:9]), 16'd1);
    @(negedge clk); ext_load_pin = 1'b0; ext_clk_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R10 clock pin high", 16'(d[10:9]), 16'd2);
    @(negedge clk); ext_clk_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sel_mask();
    logic [15:0] d;
    wr(2'd0, ctl(2, 0, 0, 0));
    wr(2'd1, 16'h0000);
    repeat (2) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = ctl(1, 0, 0, 0);
    @(negedge clk); wr_en = 1'b0; presc_en = 6'h02;
    @(negedge clk); presc_en = '0;
    tap(1);
    rd(2'd1, d); check("R11 pulse after select change dropped", d, 16'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_taps();
    t_ext_edges();
    t_wrap();
    t_free_irq();
    t_preset();
    t_load_edges();
    t_load_prio();
    t_pins();
    t_sel_mask();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired before tests completed");
    finish_run();
  end
endmodule